// File: doc/BRIEF.md
# Neuron Saturation Self-Test Wrapper

This block wraps an array of spiking neurons and finds neurons that fire without being driven, a stuck-firing fault. Each neuron has its own input selector. With the test control low, every neuron receives its usual synaptic spike. With the test control high, synaptic spikes are blocked and the wrapper sends every neuron, at the same time, one short stimulus burst of fixed length. A single test pass therefore covers the whole array.

A healthy neuron may react to that burst, but it falls silent soon after. The wrapper opens an observation window only after a guard delay that is longer than the burst and the normal response time. Any neuron spike seen inside that window cannot have come from the input. It sets a sticky error bit for that neuron. The bits stay set after the test ends, until a synchronous clear or a reset. The test is meant to run during idle periods between inference runs.

Top module: `sat_selftest`

## Requirements
- R1: With reset high at a clock edge, every error bit reads 0 after that edge and no stimulus burst is in progress.
- R2: While test_en_i is low, each nrn_drv_o bit equals the matching syn_spk_i bit in the same cycle.
- R3: While test_en_i is high, syn_spk_i has no effect on nrn_drv_o. nrn_drv_o is all ones for exactly STIM_CYC cycles, starting just after the first clock edge that samples test_en_i high, and all zeros after that.
- R4: A neuron spike is counted only at a clock edge where test_en_i has been sampled high on more than GUARD_CYC consecutive edges, that edge included. Spikes at other edges leave err_o unchanged.
- R5: A spike counted on nrn_spk_i bit i sets err_o bit i from the next cycle on, and no other bit.
- R6: Error bits stay set after test_en_i falls and during normal operation.
- R7: clear_i high at a clock edge zeroes all error bits after that edge, and takes priority over a spike counted at the same edge.
- R8: A drop of test_en_i returns nrn_drv_o to the synaptic inputs in the same cycle. A later rise starts a new burst and a new guard delay from zero.
- R9: GUARD_CYC must exceed STIM_CYC, so the observation window never overlaps the stimulus burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en_i | input | 1 | Self-test control shared by all neurons |
| clear_i | input | 1 | Synchronous clear of all error bits |
| syn_spk_i | input | N_NRN | Synaptic spikes for normal operation, one per neuron |
| nrn_drv_o | output | N_NRN | Spike input driven into each neuron |
| nrn_spk_i | input | N_NRN | Output spike of each neuron |
| err_o | output | N_NRN | Sticky saturation flag, one per neuron |

## Verification
The selector path is combinational, so nrn_drv_o is due in the same cycle as any change of test_en_i or syn_spk_i. The burst appears one edge after test_en_i rises. An error bit is due after the (GUARD_CYC+1)-th consecutive edge that samples test_en_i high, and a clear takes effect after the edge that samples it. The bench drives its inputs and reads the outputs only at falling clock edges. It runs a behavioural reference built on an integer count of test-high edges, and it compares both outputs with that reference every cycle. Targeted checks are placed in the exact cycle before and after the window opens, in the cycle after a clear, and in the cycle after a mid-burst drop.

// File: rtl/sat_st_pkg.sv
package sat_st_pkg;

    // State of the shared stimulus burst generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } stim_state_e;

    // Control carried from the shared generators to every lane
    typedef struct packed {
        logic stim;   // burst currently applied
        logic armed;  // observation window open
    } probe_ctl_t;

    // Width of a counter that must reach maxv
    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/sat_st_stim.sv
module sat_st_stim
    import sat_st_pkg::*;
#(
    parameter int unsigned STIM_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic test_en_i,
    output logic stim_o
);
    localparam int unsigned CW = cnt_width(STIM_CYC);
    localparam logic [CW-1:0] LAST = CW'(STIM_CYC - 1);

    stim_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (test_en_i) begin
                    st_d  = ST_PULSE;
                    cnt_d = '0;
                end
            end
            ST_PULSE: begin
                if (!test_en_i) begin
                    st_d = ST_IDLE;
                end else if (cnt_q == LAST) begin
                    st_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!test_en_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign stim_o = (st_q == ST_PULSE);

    // R3: a rise of the test control starts a burst on the next cycle
    assert_pulse_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(test_en_i) |=> stim_o);

    // R3: the burst exists only after an edge that sampled test high
    assert_pulse_in_test_R3: assert property (@(posedge clk) disable iff (rst)
        stim_o |-> $past(test_en_i));

endmodule

// File: rtl/sat_st_guard.sv
module sat_st_guard
    import sat_st_pkg::*;
#(
    parameter int unsigned GUARD_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic test_en_i,
    output logic armed_o
);
    localparam int unsigned GW = cnt_width(GUARD_CYC);
    localparam logic [GW-1:0] TOP = GW'(GUARD_CYC);

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !test_en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign armed_o = test_en_i && (cnt_q == TOP);

    // R4: the window is open only if the previous edge also saw test high
    assert_window_needs_history_R4: assert property (@(posedge clk) disable iff (rst)
        armed_o |-> $past(test_en_i));

    // R8: a low test control restarts the guard count
    assert_guard_restart_R8: assert property (@(posedge clk) disable iff (rst)
        !test_en_i |=> !armed_o);

endmodule

// File: rtl/sat_st_lane.sv
module sat_st_lane
    import sat_st_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       test_en_i,
    input  logic       clear_i,
    input  probe_ctl_t ctl_i,
    input  logic       syn_spk_i,
    input  logic       nrn_spk_i,
    output logic       nrn_drv_o,
    output logic       err_o
);
    logic hit;
    logic err_q;

    // Input selector: test stimulus or synaptic spike
    assign nrn_drv_o = test_en_i ? ctl_i.stim : syn_spk_i;

    // Activity during the open window is unrelated to any input
    assign hit = ctl_i.armed & nrn_spk_i;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            err_q <= 1'b0;
        end else if (hit) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    // R5: a flag rises only from a spike inside the window
    assert_set_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(ctl_i.armed && nrn_spk_i && !clear_i));

    // R6: a set flag holds without a clear
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clear_i) |=> err_q);

    // R7: a clear always wins
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !err_q);

endmodule

// File: rtl/sat_selftest.sv
module sat_selftest
    import sat_st_pkg::*;
#(
    parameter int unsigned N_NRN     = 8,
    parameter int unsigned STIM_CYC  = 2,
    parameter int unsigned GUARD_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en_i,
    input  logic             clear_i,
    input  logic [N_NRN-1:0] syn_spk_i,
    output logic [N_NRN-1:0] nrn_drv_o,
    input  logic [N_NRN-1:0] nrn_spk_i,
    output logic [N_NRN-1:0] err_o
);
    probe_ctl_t ctl;
    logic       stim;
    logic       armed;

    sat_st_stim #(.STIM_CYC(STIM_CYC)) u_stim (
        .clk       (clk),
        .rst       (rst),
        .test_en_i (test_en_i),
        .stim_o    (stim)
    );

    sat_st_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .test_en_i (test_en_i),
        .armed_o   (armed)
    );

    always_comb begin
        ctl.stim  = stim;
        ctl.armed = armed;
    end

    for (genvar g = 0; g < N_NRN; g++) begin : g_lane
        sat_st_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .test_en_i (test_en_i),
            .clear_i   (clear_i),
            .ctl_i     (ctl),
            .syn_spk_i (syn_spk_i[g]),
            .nrn_spk_i (nrn_spk_i[g]),
            .nrn_drv_o (nrn_drv_o[g]),
            .err_o     (err_o[g])
        );
    end

    // R9: parameter constraint between guard and burst
    initial begin
        assert_guard_longer_R9: assert (GUARD_CYC > STIM_CYC)
            else $error("GUARD_CYC must exceed STIM_CYC");
    end

    // R9: window and burst never coincide
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        armed |-> !stim);

    // R1: no flag in the cycle after a reset edge
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (err_o == '0));

endmodule

// File: tb/sat_selftest_bench.sv
module sat_selftest_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int STIM  = 2;
    localparam int GUARD = 6;
    localparam int TH    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ten = 1'b0;
    logic clr = 1'b0;
    logic [N-1:0] syn = '0;
    logic [N-1:0] drv;
    logic [N-1:0] nspk;
    logic [N-1:0] err;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_selftest #(.N_NRN(N), .STIM_CYC(STIM), .GUARD_CYC(GUARD)) u_sat_selftest (
        .clk       (clk),
        .rst       (rst),
        .test_en_i (ten),
        .clear_i   (clr),
        .syn_spk_i (syn),
        .nrn_drv_o (drv),
        .nrn_spk_i (nspk),
        .err_o     (err)
    );

    // Neuron stubs: 0 healthy integrate-and-fire, 1 saturated, 2 dead
    int mode [N];
    int acc  [N];
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                acc[i] = 0;
                nspk[i] <= 1'b0;
            end else if (mode[i] == 1) begin
                nspk[i] <= 1'b1;
            end else if (mode[i] == 2) begin
                nspk[i] <= 1'b0;
            end else if (drv[i]) begin
                if (acc[i] + 1 >= TH) begin
                    acc[i] = 0;
                    nspk[i] <= 1'b1;
                end else begin
                    acc[i] = acc[i] + 1;
                    nspk[i] <= 1'b0;
                end
            end else begin
                nspk[i] <= 1'b0;
            end
        end
    end

    // Reference model: count of consecutive test-high edges and flags
    int tcnt = 0;
    logic [N-1:0] err_m = '0;
    always @(posedge clk) begin
        if (rst) begin
            tcnt  <= 0;
            err_m <= '0;
        end else begin
            tcnt <= ten ? ((tcnt < 1000) ? tcnt + 1 : tcnt) : 0;
            if (clr) err_m <= '0;
            else if (ten && tcnt >= GUARD) err_m <= err_m | nspk;
        end
    end

    function automatic logic [N-1:0] drv_ref();
        if (!ten) return syn;
        return (tcnt >= 1 && tcnt <= STIM) ? '1 : '0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and compare against the model
    task automatic cyc(input string tag);
        logic [N-1:0] e;
        @(negedge clk);
        e = drv_ref();
        chk(drv === e, tag, "drive", drv, e);
        chk(err === err_m, tag, "flags", err, err_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) mode[i] = 0;
        rst = 1'b1;
        repeat (3) cyc("R1");
        chk(err === '0, "R1", "flags after reset", err, '0);
        rst = 1'b0;

        // Normal operation, saturated neurons present but no test
        mode[2] = 1; mode[5] = 1; mode[6] = 2;
        for (int k = 0; k < 6; k++) begin
            syn = 8'(8'h5A ^ (k * 8'h37));
            cyc("R2");
            chk(drv === syn, "R2", "pass-through", drv, syn);
        end
        chk(err === '0, "R4", "no flag without test", err, '0);

        // Test pass with saturated neurons 2 and 5, dead neuron 6
        syn = 8'hA5;
        ten = 1'b1;
        for (int m = 1; m <= GUARD + 1; m++) begin
            cyc("R3");
            if (m == 1) chk(drv === '1, "R3", "burst on", drv, '1);
            if (m == STIM) chk(err === '0, "R9", "no flag in burst", err, '0);
            if (m == STIM + 1) chk(drv === '0, "R3", "syn blocked", drv, '0);
            if (m == GUARD) chk(err === '0, "R4", "before window", err, '0);
            if (m == GUARD + 1) chk(err === 8'h24, "R5", "window flag", err, 8'h24);
        end

        // Flags survive the end of the test
        ten = 1'b0;
        for (int k = 0; k < 5; k++) begin
            syn = 8'(k * 8'h1D);
            cyc("R6");
        end
        chk(err === 8'h24, "R6", "sticky", err, 8'h24);

        // Clear against a simultaneous set
        ten = 1'b1;
        repeat (GUARD + 2) cyc("R5");
        clr = 1'b1;
        cyc("R7");
        chk(err === '0, "R7", "clear beats set", err, '0);
        clr = 1'b0;
        cyc("R5");
        chk(err === 8'h24, "R5", "set after clear", err, 8'h24);
        ten = 1'b0;
        clr = 1'b1;
        cyc("R7");
        chk(err === '0, "R7", "clear idle", err, '0);
        clr = 1'b0;

        // Test held too short: window never opens
        ten = 1'b1;
        repeat (GUARD) cyc("R4");
        ten = 1'b0;
        repeat (3) cyc("R4");
        chk(err === '0, "R4", "short test", err, '0);

        // Drop in the middle of the burst, then restart
        ten = 1'b1;
        cyc("R8");
        ten = 1'b0;
        syn = 8'h3C;
        cyc("R8");
        chk(drv === 8'h3C, "R8", "drop returns syn", drv, 8'h3C);
        ten = 1'b1;
        for (int m = 1; m <= GUARD + 1; m++) begin
            cyc("R8");
            if (m == 1) chk(drv === '1, "R8", "burst restarts", drv, '1);
            if (m == STIM + 1) chk(drv === '0, "R3", "burst ends", drv, '0);
            if (m == GUARD) chk(err === '0, "R8", "guard restarts", err, '0);
            if (m == GUARD + 1) chk(err === 8'h24, "R8", "flag after restart", err, 8'h24);
        end
        ten = 1'b0;

        // Reset clears flags
        rst = 1'b1;
        cyc("R1");
        chk(err === '0, "R1", "reset clears", err, '0);
        rst = 1'b0;
        cyc("R1");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule